// File: doc/BRIEF.md
# Configuration Store with Security Lock

This block holds the connection bits that configure a programmable logic array, together with a separate 64-bit signature word and a security lock. A host drives it through a single command port: an operation code, an address and a data word, qualified by a valid strobe. Every accepted command is answered by a one-cycle `done` pulse, an error flag and a read-data word. Only a full erase takes more than one cycle, and `busy` stays high while it runs.

A stored bit at 1 marks a closed connection and a bit at 0 marks an open one. Programming can only close connections, and a full erase opens them all again. Once the lock is set, the main array can no longer be read or programmed. The signature word stays readable and writable, so a locked part can still report what pattern it carries. The only way to clear the lock is a full erase, which also wipes the array and the signature. Reset puts the store into the erased, unlocked state of a blank part.

Top module: `cfg_store`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `rdata` is 0, every array word and both signature halves read as 0, and the store is unlocked.
- R2: A command is accepted at a rising edge where `cmd_valid` is 1 and `busy` is 0. Every accepted command except opcode 1 (erase) raises `done` in the cycle after the accepting edge, with `err` and `rdata` valid in that same cycle.
- R3: Opcode 2 (program) ORs `cmd_wdata` into the word at `cmd_addr`, so a 1 closes a connection and a 0 leaves it as it was. Opcode 3 (verify) returns that word on `rdata`.
- R4: Opcode 1 (erase) holds `busy` high for ERASE_CYCLES cycles after the accepting edge, then pulses `done` with `err`=0 and `rdata`=0. Afterwards every array word and the signature read as 0 and the lock is clear.
- R5: While `busy` is high, any command presented is ignored. No `done` is produced and no stored state changes.
- R6: Opcode 4 sets the lock. Opcode 7 programs the addressed word in the same way as opcode 2 and also sets the lock.
- R7: While locked, opcodes 2, 3 and 7 are refused: `done` pulses with `err`=1 and `rdata`=0.
- R8: Nothing except a completed erase clears the lock. Issuing opcode 4 while already locked completes with `err`=0.
- R9: Opcode 5 writes `cmd_wdata` into the signature half chosen by `cmd_addr[0]` (0 selects bits 31:0, 1 selects bits 63:32). Opcode 6 returns that half. Both work whether or not the store is locked.
- R10: Opcodes 2, 3 and 7 with `cmd_addr` at or above ROWS (12 by default) are refused with `err`=1 and `rdata`=0.
- R11: Opcode 0 is a no-operation. It produces no `done` and changes nothing.
- R12: Commands that complete successfully and are not reads (2, 4, 5, 7) return `err`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Array word address, or signature half select in bit 0 |
| cmd_wdata | input | WORD_W | Program or signature data |
| busy | output | 1 | Erase in progress; commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused; valid with `done` |
| rdata | output | WORD_W | Read result; valid with `done` |

## Verification
The hardest case to reach is a command that arrives in the last busy cycle of an erase. At that edge the erase completes while the strobe is still high, and that command must be neither accepted nor allowed to disturb the freshly cleared state. The bench holds program requests with all-ones data on the port through every erase cycle, including the final one. It then reads the array back and expects zeros. Random traffic with rare erases mixes lock, signature and out-of-range accesses, so the store passes through locked states whose signature contents must survive until the next erase.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ERASE     = 3'd1,
    OP_PROG      = 3'd2,
    OP_VERIFY    = 3'd3,
    OP_LOCK      = 3'd4,
    OP_SIG_WR    = 3'd5,
    OP_SIG_RD    = 3'd6,
    OP_PROG_LOCK = 3'd7
  } op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ERASE = 1'b1
  } state_e;

endpackage

// File: rtl/cfgs_array.sv
module cfgs_array #(
  parameter int ROWS   = 12,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] mem_q [ROWS];
  logic [WORD_W-1:0] mem_d [ROWS];
  logic [ROWS-1:0]   row_en;

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_en[r] = clr_i || (wr_i && (addr_i == ADDR_W'(r)));
      mem_d[r]  = clr_i ? '0 : (mem_q[r] | wdata_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_en[r]) mem_q[r] <= mem_d[r];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (addr_i == ADDR_W'(r)) rdata_o = mem_q[r];
    end
  end

  // R3: outside an erase, no stored connection ever opens
  for (genvar g = 0; g < ROWS; g++) begin : g_chk
    a_r3_prog_never_opens: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clr_i) |-> ((mem_q[g] & $past(mem_q[g])) == $past(mem_q[g])));
    // R4: an erase leaves every word open
    a_r4_erase_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (mem_q[g] == '0));
  end

endmodule

// File: rtl/cfgs_sig.sv
module cfgs_sig #(
  parameter int PARTS  = 2,
  parameter int WORD_W = 32,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);

  logic [WORD_W-1:0] part_q [PARTS];
  logic [WORD_W-1:0] part_d [PARTS];
  logic [PARTS-1:0]  part_en;

  always_comb begin
    for (int p = 0; p < PARTS; p++) begin
      part_en[p] = clr_i || (wr_i && (sel_i == SEL_W'(p)));
      part_d[p]  = clr_i ? '0 : wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PARTS; p++) part_q[p] <= '0;
    end else begin
      for (int p = 0; p < PARTS; p++) begin
        if (part_en[p]) part_q[p] <= part_d[p];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < PARTS; p++) begin
      if (sel_i == SEL_W'(p)) rdata_o = part_q[p];
    end
  end

  // R4: erase wipes the signature
  for (genvar g = 0; g < PARTS; g++) begin : g_chk
    a_r4_sig_wiped: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (part_q[g] == '0));
  end

endmodule

// File: rtl/cfgs_ctrl.sv
module cfgs_ctrl
  import cfgs_pkg::*;
#(
  parameter int ROWS         = 12,
  parameter int WORD_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  op_e               cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0] arr_rdata_i,
  input  logic [WORD_W-1:0] sig_rdata_i,
  output logic              arr_wr_o,
  output logic              clr_o,
  output logic              sig_wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int CNT_W = $clog2(ERASE_CYCLES) + 1;
  localparam logic [CNT_W-1:0]  CNT_LOAD = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [ADDR_W:0]   ROWS_L   = (ADDR_W + 1)'(ROWS);

  state_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              lock_q, lock_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              acc, addr_ok, rsp_en, cnt_en, lock_en;

  assign acc     = cmd_valid_i && (state_q == ST_IDLE);
  assign addr_ok = {1'b0, cmd_addr_i} < ROWS_L;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    lock_d   = lock_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    rdata_d  = '0;
    arr_wr_o = 1'b0;
    sig_wr_o = 1'b0;
    clr_o    = 1'b0;
    if (state_q == ST_ERASE) begin
      if (cnt_q == '0) begin
        state_d = ST_IDLE;
        clr_o   = 1'b1;
        lock_d  = 1'b0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (cmd_valid_i) begin
      unique case (cmd_op_i)
        OP_ERASE: begin
          state_d = ST_ERASE;
          cnt_d   = CNT_LOAD;
        end
        OP_PROG, OP_PROG_LOCK: begin
          done_d = 1'b1;
          if (lock_q || !addr_ok) begin
            err_d = 1'b1;
          end else begin
            arr_wr_o = 1'b1;
            if (cmd_op_i == OP_PROG_LOCK) lock_d = 1'b1;
          end
        end
        OP_VERIFY: begin
          done_d = 1'b1;
          if (lock_q || !addr_ok) err_d = 1'b1;
          else rdata_d = arr_rdata_i;
        end
        OP_LOCK: begin
          done_d = 1'b1;
          lock_d = 1'b1;
        end
        OP_SIG_WR: begin
          done_d   = 1'b1;
          sig_wr_o = 1'b1;
        end
        OP_SIG_RD: begin
          done_d  = 1'b1;
          rdata_d = sig_rdata_i;
        end
        default: ;
      endcase
    end
  end

  assign rsp_en  = done_d || done_q;
  assign cnt_en  = (state_q == ST_ERASE) || acc;
  assign lock_en = lock_d != lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      lock_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (lock_en) lock_q <= lock_d;
      if (rsp_en) begin
        err_q   <= err_d;
        rdata_q <= rdata_d;
      end
    end
  end

  assign busy_o  = (state_q == ST_ERASE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;

  // R5: no completion while an erase still has cycles to run
  a_r5_quiet_mid_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q != '0) |=> !done_o);
  // R7: a verify on a locked store answers with an error and zero data
  a_r7_locked_verify_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lock_q && cmd_op_i == OP_VERIFY) |=> (done_o && err_o && rdata_o == '0));
  // R8: the lock falls only at the end of an erase
  a_r8_lock_only_by_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(clr_o));
  // R2: a single-cycle command answers on the next cycle
  a_r2_prompt_done: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op_i != OP_NOP && cmd_op_i != OP_ERASE) |=> done_o);
  // R11: a no-operation leaves no completion behind
  a_r11_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op_i == OP_NOP) |=> !done_o);

endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfgs_pkg::*;
#(
  parameter int ROWS         = 12,
  parameter int WORD_W       = 32,
  parameter int ADDR_W       = 4,
  parameter int SIG_W        = 64,
  parameter int ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);

  localparam int SIG_PARTS = SIG_W / WORD_W;
  localparam int SEL_W     = (SIG_PARTS > 1) ? $clog2(SIG_PARTS) : 1;

  logic              rst_meta, rst_s;
  logic [WORD_W-1:0] arr_rdata, sig_rdata;
  logic              arr_wr, clr, sig_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  cfgs_ctrl #(
    .ROWS(ROWS), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s),
    .cmd_valid_i(cmd_valid), .cmd_op_i(op_e'(cmd_op)), .cmd_addr_i(cmd_addr),
    .arr_rdata_i(arr_rdata), .sig_rdata_i(sig_rdata),
    .arr_wr_o(arr_wr), .clr_o(clr), .sig_wr_o(sig_wr),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata)
  );

  cfgs_array #(.ROWS(ROWS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_s), .clr_i(clr), .wr_i(arr_wr),
    .addr_i(cmd_addr), .wdata_i(cmd_wdata), .rdata_o(arr_rdata)
  );

  cfgs_sig #(.PARTS(SIG_PARTS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_sig (
    .clk(clk), .rst_n(rst_s), .clr_i(clr), .wr_i(sig_wr),
    .sel_i(cmd_addr[SEL_W-1:0]), .wdata_i(cmd_wdata), .rdata_o(sig_rdata)
  );

endmodule

// File: tb/sim_cfg_store.sv
module sim_cfg_store;

  localparam int ROWS = 12;
  localparam int WW   = 32;
  localparam int AW   = 4;
  localparam int EC   = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic          busy, done, err;
  logic [WW-1:0] rdata;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] m_mem [ROWS];
  logic [WW-1:0] m_sig [2];
  logic          m_lock;

  always #10 clk = ~clk;

  cfg_store #(.ROWS(ROWS), .WORD_W(WW), .ADDR_W(AW), .SIG_W(64), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit refused(input logic [2:0] op, input logic [AW-1:0] a);
    if (op == 3'd2 || op == 3'd3 || op == 3'd7) return m_lock || (a >= AW'(ROWS));
    return 1'b0;
  endfunction

  function automatic logic [WW-1:0] exp_rd(input logic [2:0] op, input logic [AW-1:0] a);
    if (refused(op, a)) return '0;
    if (op == 3'd3) return m_mem[a];
    if (op == 3'd6) return m_sig[a[0]];
    return '0;
  endfunction

  task automatic model_erase();
    for (int r = 0; r < ROWS; r++) m_mem[r] = '0;
    m_sig[0] = '0; m_sig[1] = '0; m_lock = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [WW-1:0] wd, input string req);
    logic [WW-1:0] er;
    bit            ee;
    int            n;
    er = exp_rd(op, a);
    ee = refused(op, a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (op == 3'd1) begin
      n = 1;
      // R5: hold a program request with all ones through the whole erase
      while (!done && n <= EC + 2) begin
        chk(busy == 1'b1, "R4 busy during erase", WW'(busy), 1);
        cmd_valid = 1'b1; cmd_op = 3'd2; cmd_addr = AW'(n % ROWS); cmd_wdata = '1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n++;
      end
      chk(n == EC + 1, "R4 erase length", WW'(n), WW'(EC + 1));
      chk(done && !busy && !err && rdata == '0, "R4 erase completion", rdata, '0);
      model_erase();
      @(negedge clk);
      chk(!done, "R5 ignored command gave no done", WW'(done), 0);
    end else if (op == 3'd0) begin
      chk(!done && !busy, "R11 nop silent", WW'(done), 0);
    end else begin
      chk(done == 1'b1, "R2 done pulse", WW'(done), 1);
      chk(err == ee, $sformatf("R7 R10 err op%0d", op), WW'(err), WW'(ee));
      chk(rdata == er, $sformatf("R3 R9 R12 rdata op%0d", op), rdata, er);
      if (!ee) begin
        case (op)
          3'd2: m_mem[a] = m_mem[a] | wd;
          3'd7: begin m_mem[a] = m_mem[a] | wd; m_lock = 1'b1; end
          3'd4: m_lock = 1'b1;
          3'd5: m_sig[a[0]] = wd;
          default: ;
        endcase
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    logic [2:0] op;
    seed = $urandom(32'h5eed);
    model_erase();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!busy && !done && !err && rdata == '0, "R1 reset outputs", rdata, '0);
    issue(3'd3, 4'd0, '0, "R1");
    issue(3'd6, 4'd1, '0, "R1");
    // R3
    issue(3'd2, 4'd3, 32'h00F0_000F, "R3");
    issue(3'd2, 4'd3, 32'h0000_0F00, "R3");
    issue(3'd2, 4'd3, 32'h0, "R3");
    issue(3'd3, 4'd3, '0, "R3");
    issue(3'd2, 4'd11, 32'hDEAD_BEEF, "R3");
    issue(3'd3, 4'd11, '0, "R3");
    // R10
    issue(3'd2, 4'd12, 32'hFFFF_FFFF, "R10");
    issue(3'd3, 4'd15, '0, "R10");
    // R9
    issue(3'd5, 4'd0, 32'h1234_5678, "R9");
    issue(3'd5, 4'd1, 32'h9ABC_DEF0, "R9");
    issue(3'd6, 4'd0, '0, "R9");
    issue(3'd6, 4'd1, '0, "R9");
    // R11
    issue(3'd0, 4'd3, 32'hFFFF_FFFF, "R11");
    issue(3'd3, 4'd3, '0, "R11");
    // R6 R7 R8
    issue(3'd4, 4'd0, '0, "R6");
    issue(3'd3, 4'd3, '0, "R7");
    issue(3'd2, 4'd3, 32'hFFFF_FFFF, "R7");
    issue(3'd7, 4'd4, 32'h1, "R7");
    issue(3'd6, 4'd1, '0, "R9");
    issue(3'd5, 4'd0, 32'hCAFE_0001, "R9");
    issue(3'd6, 4'd0, '0, "R9");
    issue(3'd4, 4'd0, '0, "R8");
    // R4 R5
    issue(3'd1, 4'd0, '0, "R4");
    issue(3'd3, 4'd3, '0, "R4");
    issue(3'd3, 4'd1, '0, "R5");
    issue(3'd6, 4'd0, '0, "R4");
    // R6 program-and-lock
    issue(3'd7, 4'd5, 32'h0000_00A5, "R6");
    issue(3'd3, 4'd5, '0, "R6");
    issue(3'd1, 4'd0, '0, "R4");
    issue(3'd3, 4'd5, '0, "R4");
    // random traffic
    for (int i = 0; i < 600; i++) begin
      op = 3'($urandom_range(0, 7));
      if (op == 3'd1 && $urandom_range(0, 9) != 0) op = 3'd3;
      if ((op == 3'd4 || op == 3'd7) && $urandom_range(0, 3) != 0) op = 3'd2;
      issue(op, AW'($urandom_range(0, 15)), $urandom(), "RND");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule